// File: doc/BRIEF.md
# Configurable Registered Macrocell Cell

This block is one programmable logic output cell. It takes one sum-of-products term, `sop_i`. A static configuration word turns the cell into a D flip-flop, a T flip-flop, or a combinational pass-through. It selects the clock from four global clock lines and two control-term lines. For a global clock, the configuration also picks the rising or the falling edge. Two control terms act as asynchronous clear and set, and the configuration can turn both off.

An output-enable selector chooses one of four control terms, or forces the pad on or off. A global active-low tri-state input can override the selector. The cell has two feedback outputs:
- macrocell feedback, taken before the pad driver;
- pin feedback, taken after the pad model.

Every clock source and control term is a level signal. The cell samples these levels on the system clock `clk`. An edge of the selected source is detected at the first `clk` rising edge that samples the new level. The register updates at that same `clk` edge. No port is a data stream, so no port has a valid/ready handshake. The configuration is static: the cell captures it only while reset is held.

Top module: `mcell_cell`

## Requirements
- R1: Configuration bits [10:9] select the storage mode.
  - 01 (D) loads `sop_i` at an active clock edge.
  - 10 (T) inverts the register at an active clock edge when `sop_i` is 1.
  - 00 and 11 are combinational: `mc_fb_o` and `pad_o` follow `sop_i` in the same cycle, and the register is unused.
- R2: Bits [8:6] select the clock source: 0 to 3 pick `gclk_i[0..3]`, 4 picks `ct_i[2]`, 5 picks `ct_i[3]`, and 6 or 7 select no clock. Edges on unselected sources have no effect. An edge is detected at the first `clk` rising edge that samples the changed level, and the register updates at that edge.
- R3: Bit [5] set makes a global clock act on its falling edge, and bit [5] clear makes it act on its rising edge. The two control-term clocks always act on the rising edge.
- R4: With bit [4] set:
  - `ct_i[0]` forces the register to 0 and `ct_i[1]` forces it to 1. `mc_fb_o` shows the forced value in the same cycle.
  - The forced value stays after the control term is released.
  - With bit [4] clear, both control terms are ignored.
- R5: While `rst_n` is low the register is 0, and it still reads 0 on the first cycle after reset is released.
- R6: Bits [3:1] select the output enable: 0 to 3 pick `ct_i[2..5]`, 4 means always enabled, and 5 to 7 mean always disabled.
- R7: With bit [0] set, a low `gts_n_i` forces `pad_oe_o` to 0. With bit [0] clear, `gts_n_i` is ignored.
- R8: `mc_fb_o` always carries the cell value, whatever the output enable. `pin_fb_o` equals `pad_o` when `pad_oe_o` is 1 and equals `pad_in_i` otherwise.
- R9: When clear and set are asserted together, clear wins.
- R10: `cfg_i` is captured only while `rst_n` is low. Changes to `cfg_i` after reset is released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every source |
| rst_n | input | 1 | Active-low reset; the configuration is loaded while it is low |
| cfg_i | input | 11 | Configuration word |
| gclk_i | input | 4 | Global clock levels |
| ct_i | input | 6 | Control-term levels |
| sop_i | input | 1 | Sum-of-products data term |
| gts_n_i | input | 1 | Global tri-state, active low |
| pad_in_i | input | 1 | Level driven onto the pin from outside |
| pad_o | output | 1 | Value the pad driver presents |
| pad_oe_o | output | 1 | Pad driver enable |
| mc_fb_o | output | 1 | Macrocell feedback, before the driver |
| pin_fb_o | output | 1 | Pin feedback, after the driver |

## Verification
The assertions check the following on every cycle:
- D capture and T toggle on a detected edge;
- that the register holds when there is neither an edge nor a clear or set;
- clear priority and set action;
- zero after reset;
- the global tri-state override;
- that the captured configuration is frozen.

Other behaviour shows only in the bench's scenarios:
- which source and which polarity produce an edge;
- that the asynchronous value appears in the same cycle and stays after the control term is released;
- the output-enable selection;
- pin feedback following the external level;
- `cfg_i` changes after reset having no effect.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int GCLK_N  = 4;
  localparam int CTCLK_N = 2;
  localparam int SRC_N   = GCLK_N + CTCLK_N;
  localparam int SEL_W   = $clog2(SRC_N);
  localparam int CT_N    = 6;
  localparam int OE_SRC  = 4;
  localparam int OE_BASE = 2;
  localparam int OE_W    = 3;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_DFF   = 2'd1,
    MODE_TFF   = 2'd2,
    MODE_COMB2 = 2'd3
  } cell_mode_e;

  typedef struct packed {
    cell_mode_e         mode;
    logic [SEL_W-1:0]   clk_sel;
    logic               clk_fall;
    logic               init_en;
    logic [OE_W-1:0]    oe_sel;
    logic               gts_en;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/mcell_clk_pick.sv
module mcell_clk_pick
  import mcell_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GCLK_N-1:0]   gclk_i,
  input  logic [CTCLK_N-1:0]  ctclk_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                fall_i,
  output logic                fire_o
);
  logic [SRC_N-1:0] src_now;
  logic [SRC_N-1:0] src_prev;
  logic [SRC_N-1:0] edge_v;

  assign src_now = {ctclk_i, gclk_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= '0;
    else        src_prev <= src_now;
  end

  for (genvar i = 0; i < SRC_N; i++) begin : g_edge
    if (i < GCLK_N) begin : g_glob
      assign edge_v[i] = fall_i ? (~src_now[i] & src_prev[i])
                                : (src_now[i] & ~src_prev[i]);
    end else begin : g_ct
      assign edge_v[i] = src_now[i] & ~src_prev[i];
    end
  end

  always_comb begin
    fire_o = 1'b0;
    for (int i = 0; i < SRC_N; i++) begin
      if (sel_i == SEL_W'(i)) fire_o = edge_v[i];
    end
  end

  // R2
  no_ghost_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (32'(sel_i) < SRC_N));
endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cell_mode_e  mode_i,
  input  logic        init_en_i,
  input  logic        clr_i,
  input  logic        set_i,
  input  logic        fire_i,
  input  logic        sop_i,
  output logic        q_o
);
  logic q_r;
  logic init_clr;
  logic init_set;
  logic reg_mode;

  assign init_clr = init_en_i & clr_i;
  assign init_set = init_en_i & set_i & ~clr_i;
  assign reg_mode = (mode_i == MODE_DFF) || (mode_i == MODE_TFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (init_clr) begin
      q_r <= 1'b0;
    end else if (init_set) begin
      q_r <= 1'b1;
    end else if (fire_i) begin
      unique case (mode_i)
        MODE_DFF: q_r <= sop_i;
        MODE_TFF: q_r <= q_r ^ sop_i;
        default:  q_r <= q_r;
      endcase
    end
  end

  assign q_o = init_clr ? 1'b0 : (init_set ? 1'b1 : q_r);

  // R5
  zero_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_r == 1'b0));
  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_en_i && clr_i) |=> (q_r == 1'b0));
  // R4
  set_loads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_en_i && set_i && !clr_i) |=> (q_r == 1'b1));
  // R1
  d_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && mode_i == MODE_DFF && !init_en_i) |=> (q_r == $past(sop_i)));
  // R1
  t_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && mode_i == MODE_TFF && !init_en_i) |=> (q_r == ($past(q_r) ^ $past(sop_i))));
  // R2
  hold_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fire_i && reg_mode) && !(init_en_i && (clr_i || set_i))) |=> $stable(q_r));
endmodule

// File: rtl/mcell_oe.sv
module mcell_oe
  import mcell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CT_N-1:0]   ct_i,
  input  logic [OE_W-1:0]   oe_sel_i,
  input  logic              gts_en_i,
  input  logic              gts_n_i,
  output logic              oe_o
);
  logic oe_pick;

  always_comb begin
    oe_pick = 1'b0;
    for (int i = 0; i < OE_SRC; i++) begin
      if (oe_sel_i == OE_W'(i)) oe_pick = ct_i[OE_BASE + i];
    end
    if (oe_sel_i == OE_W'(OE_SRC)) oe_pick = 1'b1;
  end

  assign oe_o = oe_pick & ~(gts_en_i & ~gts_n_i);

  // R7
  gts_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gts_en_i && !gts_n_i) |-> !oe_o);
  // R6
  never_setting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(oe_sel_i) > OE_SRC) |-> !oe_o);
endmodule

// File: rtl/mcell_cell.sv
module mcell_cell
  import mcell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [GCLK_N-1:0] gclk_i,
  input  logic [CT_N-1:0]   ct_i,
  input  logic              sop_i,
  input  logic              gts_n_i,
  input  logic              pad_in_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              mc_fb_o,
  output logic              pin_fb_o
);
  cell_cfg_t cfg_q;
  logic      fire;
  logic      q_val;
  logic      comb_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= cell_cfg_t'(cfg_i);
  end

  mcell_clk_pick u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gclk_i  (gclk_i),
    .ctclk_i (ct_i[3:2]),
    .sel_i   (cfg_q.clk_sel),
    .fall_i  (cfg_q.clk_fall),
    .fire_o  (fire)
  );

  mcell_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (cfg_q.mode),
    .init_en_i (cfg_q.init_en),
    .clr_i     (ct_i[0]),
    .set_i     (ct_i[1]),
    .fire_i    (fire),
    .sop_i     (sop_i),
    .q_o       (q_val)
  );

  mcell_oe u_oe (
    .clk      (clk),
    .rst_n    (rst_n),
    .ct_i     (ct_i),
    .oe_sel_i (cfg_q.oe_sel),
    .gts_en_i (cfg_q.gts_en),
    .gts_n_i  (gts_n_i),
    .oe_o     (pad_oe_o)
  );

  assign comb_mode = (cfg_q.mode == MODE_COMB) || (cfg_q.mode == MODE_COMB2);
  assign mc_fb_o   = comb_mode ? sop_i : q_val;
  assign pad_o     = mc_fb_o;
  assign pin_fb_o  = pad_oe_o ? pad_o : pad_in_i;

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_q));
endmodule

// File: tb/mcell_cell_bench.sv
module mcell_cell_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cfg_i = '0;
  logic [3:0]  gclk_i = '0;
  logic [5:0]  ct_i = '0;
  logic        sop_i = 1'b0;
  logic        gts_n_i = 1'b1;
  logic        pad_in_i = 1'b0;
  logic        pad_o, pad_oe_o, mc_fb_o, pin_fb_o;

  int chk_n = 0;
  int fail_n = 0;
  logic [10:0] lat;
  logic        exp_q;
  logic [5:0]  prev;

  always #4 clk = ~clk;

  mcell_cell u_mcell_cell (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .gclk_i(gclk_i), .ct_i(ct_i),
    .sop_i(sop_i), .gts_n_i(gts_n_i), .pad_in_i(pad_in_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .mc_fb_o(mc_fb_o), .pin_fb_o(pin_fb_o)
  );

  function automatic logic [10:0] mk_cfg(input logic [1:0] m, input logic [2:0] sel,
      input logic fall, input logic ini, input logic [2:0] oe, input logic gts);
    return {m, sel, fall, ini, oe, gts};
  endfunction

  function automatic logic is_comb(input logic [10:0] c);
    return (c[10:9] == 2'd0) || (c[10:9] == 2'd3);
  endfunction

  function automatic logic exp_fb(input logic [10:0] c, input logic [5:0] ct,
      input logic s, input logic q);
    if (is_comb(c)) return s;
    if (c[4] && ct[0]) return 1'b0;
    if (c[4] && ct[1]) return 1'b1;
    return q;
  endfunction

  function automatic logic exp_oe(input logic [10:0] c, input logic [5:0] ct, input logic gn);
    logic o;
    case (c[3:1])
      3'd0: o = ct[2];
      3'd1: o = ct[3];
      3'd2: o = ct[4];
      3'd3: o = ct[5];
      3'd4: o = 1'b1;
      default: o = 1'b0;
    endcase
    if (c[0] && !gn) o = 1'b0;
    return o;
  endfunction

  function automatic logic exp_edge(input logic [10:0] c, input logic [5:0] s, input logic [5:0] p);
    int k = int'(c[8:6]);
    if (k < 4) return c[5] ? (~s[k] & p[k]) : (s[k] & ~p[k]);
    if (k < 6) return s[k] & ~p[k];
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic expv);
    chk_n++;
    if (act !== expv) begin
      fail_n++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic do_reset(input logic [10:0] c);
    @(negedge clk);
    rst_n = 1'b0; cfg_i = c; gclk_i = '0; ct_i = '0; sop_i = 1'b0;
    gts_n_i = 1'b1; pad_in_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lat = c; exp_q = 1'b0; prev = '0;
  endtask

  // Called at a negedge: drive, check combinational view, pass one posedge.
  task automatic cycle(input logic [3:0] g, input logic [5:0] c, input logic s,
      input logic gn, input logic pi, input logic [10:0] noise, input string tag);
    logic fb, oe, fire, clr, set;
    string t_fb, t_oe, t_pin;
    logic [5:0] src;
    gclk_i = g; ct_i = c; sop_i = s; gts_n_i = gn; pad_in_i = pi; cfg_i = noise;
    #1;
    fb = exp_fb(lat, c, s, exp_q);
    oe = exp_oe(lat, c, gn);
    clr = lat[4] & c[0];
    set = lat[4] & c[1] & ~c[0];
    t_fb  = (tag != "") ? tag : ((!is_comb(lat) && (clr || set)) ? "R4" : "R1");
    t_oe  = (tag != "") ? tag : ((lat[0] && !gn) ? "R7" : "R6");
    t_pin = (tag != "") ? tag : "R8";
    chk(t_fb, "mc_fb", mc_fb_o, fb);
    chk(t_fb, "pad_o", pad_o, fb);
    chk(t_oe, "pad_oe", pad_oe_o, oe);
    chk(t_pin, "pin_fb", pin_fb_o, oe ? fb : pi);
    @(posedge clk);
    src = {c[3], c[2], g};
    fire = exp_edge(lat, src, prev);
    if (clr) exp_q = 1'b0;
    else if (set) exp_q = 1'b1;
    else if (fire && lat[10:9] == 2'd1) exp_q = s;
    else if (fire && lat[10:9] == 2'd2) exp_q = exp_q ^ s;
    prev = src;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fail_n++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [10:0] base;
    void'($urandom(32'd7321));

    // R5: zero after reset, D on rising gclk0, init enabled, oe always on
    base = mk_cfg(2'd1, 3'd0, 1'b0, 1'b1, 3'd4, 1'b1);
    do_reset(base);
    cycle(4'h0, 6'h00, 1'b0, 1'b1, 1'b0, base, "R5");
    // R1 D capture then hold
    cycle(4'h1, 6'h00, 1'b1, 1'b1, 1'b0, base, "R1");
    cycle(4'h0, 6'h00, 1'b0, 1'b1, 1'b0, base, "R1");
    chk("R1", "d_held", mc_fb_o, 1'b1);
    // R9 clear and set together
    cycle(4'h0, 6'h03, 1'b0, 1'b1, 1'b0, base, "R9");
    cycle(4'h0, 6'h00, 1'b0, 1'b1, 1'b0, base, "R9");
    chk("R9", "clear_won", mc_fb_o, 1'b0);
    // R4 set, persistence
    cycle(4'h0, 6'h02, 1'b0, 1'b1, 1'b0, base, "R4");
    cycle(4'h0, 6'h00, 1'b0, 1'b1, 1'b0, base, "R4");
    chk("R4", "set_persists", mc_fb_o, 1'b1);
    // R7 global tri-state, R8 pin follows external level
    cycle(4'h0, 6'h00, 1'b0, 1'b0, 1'b0, base, "R7");
    chk("R8", "pin_ext", pin_fb_o, 1'b0);
    // R10: cfg_i now says combinational, cell stays registered
    cycle(4'h0, 6'h00, 1'b0, 1'b1, 1'b0, mk_cfg(2'd0, 3'd0, 1'b0, 1'b0, 3'd7, 1'b0), "R10");
    chk("R10", "still_reg", mc_fb_o, 1'b1);

    // R3: falling edge of gclk2; T mode
    base = mk_cfg(2'd2, 3'd2, 1'b1, 1'b0, 3'd2, 1'b0);
    do_reset(base);
    cycle(4'h4, 6'h10, 1'b1, 1'b0, 1'b1, base, "R3");
    cycle(4'h0, 6'h10, 1'b1, 1'b0, 1'b1, base, "R3");
    chk("R3", "fall_toggle", mc_fb_o, 1'b1);
    // R4 disabled: clear term ignored
    cycle(4'h0, 6'h01, 1'b0, 1'b1, 1'b0, base, "R4");
    chk("R4", "init_off", mc_fb_o, 1'b1);

    // R2: clock from ct_i[3]; global clocks ignored
    base = mk_cfg(2'd1, 3'd5, 1'b0, 1'b0, 3'd1, 1'b0);
    do_reset(base);
    cycle(4'hF, 6'h00, 1'b1, 1'b1, 1'b0, base, "R2");
    cycle(4'h0, 6'h00, 1'b1, 1'b1, 1'b0, base, "R2");
    chk("R2", "gclk_ignored", mc_fb_o, 1'b0);
    cycle(4'h0, 6'h08, 1'b1, 1'b1, 1'b0, base, "R2");
    cycle(4'h0, 6'h08, 1'b0, 1'b1, 1'b0, base, "R6");
    chk("R2", "ct_clock", mc_fb_o, 1'b1);

    // Random rounds: new config each round, cfg_i noise every cycle
    for (int r = 0; r < 24; r++) begin
      base = 11'($urandom);
      do_reset(base);
      for (int n = 0; n < 200; n++) begin
        logic [5:0] c;
        c = 6'($urandom);
        if (($urandom % 8) != 0) c[1:0] = 2'b00;
        cycle(4'($urandom), c, 1'($urandom), (($urandom % 4) != 0), 1'($urandom),
              11'($urandom), "");
      end
    end
    finish_run();
  end
endmodule